// File: doc/BRIEF.md
# Strided Copy Command Chunker

This block takes a single rectangular copy job and breaks it into a stream of commands for a downstream copy engine. A job names a source and a destination buffer by base offset and row pitch, gives a rectangle origin in each, a width in pixels, a pixel size in bytes and a line count. The block works out the byte offset of the first line on each side and then issues copy commands. Each command moves a bounded number of lines, and the offsets move forward between commands.

A second job form describes a flat run of bytes. The chunker treats the run as a stack of 4096-byte lines, using the same line limit per command. Any tail shorter than one page is sent last as a single-line command.

Every copy command is followed by two marker items, a no-op and then an output-offset reset. The data mover needs these before it accepts the next copy. Commands leave over a valid/ready handshake. The job side accepts a new job only while the block is idle.

Top module: `strided_copy_chunker`

## Requirements
- R1: In strided mode the first copy command carries source offset srcBase + srcY*srcPitch + srcX*bytesPerPx and destination offset dstBase + dstY*dstPitch + dstX*bytesPerPx. Both pitches are passed through unchanged.
- R2: A copy command never carries more than 2047 lines or zero lines. A job of N lines is sent as full 2047-line commands followed by one command with the rest.
- R3: After a copy command is accepted, each offset advances by its own pitch multiplied by the lines that command carried.
- R4: In strided mode the line length field equals widthPx multiplied by bytesPerPx.
- R5: cmdKind encodes copy as 0, no-op as 1 and output-offset reset as 2. Every accepted copy is followed by a no-op and then by an output-offset reset before any further copy. On both marker items every data field is zero.
- R6: In flat mode (jobFlat = 1), floor(flatLen/4096) page lines are sent starting at srcBase and dstBase. Both pitches and the line length are 4096, and the R2 limit applies per command.
- R7: In flat mode a leftover of flatLen mod 4096 bytes, if nonzero, is sent after all page commands as one command of one line. Both its pitches and its line length equal the leftover. Its offsets are the bases plus the page bytes already sent.
- R8: A strided job with lineCount = 0, or a flat job with flatLen = 0, produces no command, and done pulses on the second clock edge after the job is accepted.
- R9: While cmdValid is high and cmdReady is low, cmdValid stays high and no command field changes.
- R10: jobReady is high only while no command is pending. done is a one-cycle pulse raised by the clock edge that accepts the final output-offset reset of a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| jobValid | input | 1 | Job request |
| jobReady | output | 1 | Block idle, job taken on this edge if jobValid |
| jobFlat | input | 1 | 1 selects flat byte-run mode |
| srcBase | input | OFF_W | Source base offset |
| dstBase | input | OFF_W | Destination base offset |
| srcPitch | input | PITCH_W | Source row pitch in bytes |
| dstPitch | input | PITCH_W | Destination row pitch in bytes |
| srcX | input | DIM_W | Source rectangle origin column |
| srcY | input | DIM_W | Source rectangle origin row |
| dstX | input | DIM_W | Destination rectangle origin column |
| dstY | input | DIM_W | Destination rectangle origin row |
| widthPx | input | DIM_W | Rectangle width in pixels |
| bytesPerPx | input | BPP_W | Bytes per pixel |
| lineCount | input | DIM_W | Rectangle height in lines |
| flatLen | input | LEN_W | Byte count in flat mode |
| cmdValid | output | 1 | Command item available |
| cmdReady | input | 1 | Copy engine takes the item |
| cmdKind | output | 2 | 0 copy, 1 no-op, 2 output-offset reset |
| cmdSrcOff | output | OFF_W | Source offset of the command |
| cmdDstOff | output | OFF_W | Destination offset of the command |
| cmdSrcPitch | output | PITCH_W | Source pitch of the command |
| cmdDstPitch | output | PITCH_W | Destination pitch of the command |
| cmdLineBytes | output | DIM_W+BPP_W | Bytes per line |
| cmdLines | output | clog2(MAX_LINES+1) | Lines in the command |
| done | output | 1 | One-cycle job completion pulse |

## Verification
A job taken on clock edge E0 produces its first copy item in the cycle after edge E1, because one setup edge sits between them. Each later item appears in the cycle after the edge that accepted the one before it. done is high in the cycle after the final reset item is accepted. For an empty job it is high in the cycle after E1.

The bench drives inputs and samples outputs on falling edges. It compares the first item exactly two falling edges after submission and checks every marker item in turn. It holds cmdReady low for several cycles to check that the fields stay put. It checks done on the first falling edge after the last acceptance and checks it low again one cycle later. All expected offsets and chunk sizes are rebuilt in the bench from the formulas in the requirements.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [1:0] {
    KIND_COPY  = 2'd0,
    KIND_NOP   = 2'd1,
    KIND_FLUSH = 2'd2
  } cmd_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;     // capture job, compute start offsets
    logic      advance;  // copy accepted: step offsets, drop line count
    logic      loadRem;  // switch to the flat tail command
    cmd_kind_e kind;     // item currently presented
  } dp_ctrl_t;

endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     jobValid,
  input  logic     cmdReady,
  input  logic     haveLines,
  input  logic     haveRem,
  output logic     jobReady,
  output logic     cmdValid,
  output logic     done,
  output dp_ctrl_t ctl
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_COPY, ST_NOP, ST_FLUSH
  } state_e;

  state_e state, stateNext;
  logic   finish;
  logic   doneR;

  // picks what follows setup or a completed marker pair
  function automatic void pickNext(input logic lines, input logic rem,
                                   output state_e nxt, output logic takeRem,
                                   output logic fin);
    takeRem = 1'b0;
    fin     = 1'b0;
    if (lines) begin
      nxt = ST_COPY;
    end else if (rem) begin
      nxt     = ST_COPY;
      takeRem = 1'b1;
    end else begin
      nxt = ST_IDLE;
      fin = 1'b1;
    end
  endfunction

  always_comb begin
    stateNext   = state;
    ctl.load    = 1'b0;
    ctl.advance = 1'b0;
    ctl.loadRem = 1'b0;
    ctl.kind    = KIND_COPY;
    finish      = 1'b0;
    jobReady    = (state == ST_IDLE);
    cmdValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (jobValid) begin
          ctl.load  = 1'b1;
          stateNext = ST_SETUP;
        end
      end
      ST_SETUP: begin
        pickNext(haveLines, haveRem, stateNext, ctl.loadRem, finish);
      end
      ST_COPY: begin
        cmdValid = 1'b1;
        ctl.kind = KIND_COPY;
        if (cmdReady) begin
          ctl.advance = 1'b1;
          stateNext   = ST_NOP;
        end
      end
      ST_NOP: begin
        cmdValid = 1'b1;
        ctl.kind = KIND_NOP;
        if (cmdReady) stateNext = ST_FLUSH;
      end
      ST_FLUSH: begin
        cmdValid = 1'b1;
        ctl.kind = KIND_FLUSH;
        if (cmdReady) pickNext(haveLines, haveRem, stateNext, ctl.loadRem, finish);
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      doneR <= 1'b0;
    end else begin
      state <= stateNext;
      doneR <= finish;
    end
  end

  assign done = doneR;

endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int PITCH_W    = 16,
  parameter int DIM_W      = 16,
  parameter int BPP_W      = 3,
  parameter int LEN_W      = 32,
  parameter int MAX_LINES  = 2047,
  parameter int PAGE_SHIFT = 12,
  localparam int LB_W      = DIM_W + BPP_W,
  localparam int LINES_W   = $clog2(MAX_LINES + 1),
  localparam int CNT_W     = (DIM_W > LEN_W - PAGE_SHIFT) ? DIM_W : LEN_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dp_ctrl_t           ctl,
  input  logic               jobFlat,
  input  logic [OFF_W-1:0]   srcBase,
  input  logic [OFF_W-1:0]   dstBase,
  input  logic [PITCH_W-1:0] srcPitch,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [DIM_W-1:0]   srcX,
  input  logic [DIM_W-1:0]   srcY,
  input  logic [DIM_W-1:0]   dstX,
  input  logic [DIM_W-1:0]   dstY,
  input  logic [DIM_W-1:0]   widthPx,
  input  logic [BPP_W-1:0]   bytesPerPx,
  input  logic [DIM_W-1:0]   lineCount,
  input  logic [LEN_W-1:0]   flatLen,
  output logic               haveLines,
  output logic               haveRem,
  output logic [OFF_W-1:0]   outSrcOff,
  output logic [OFF_W-1:0]   outDstOff,
  output logic [PITCH_W-1:0] outSrcPitch,
  output logic [PITCH_W-1:0] outDstPitch,
  output logic [LB_W-1:0]    outLineBytes,
  output logic [LINES_W-1:0] outLines
);

  localparam logic [PITCH_W-1:0] PAGE_PITCH = PITCH_W'(1) << PAGE_SHIFT;
  localparam logic [LB_W-1:0]    PAGE_LB    = LB_W'(1) << PAGE_SHIFT;
  localparam logic [CNT_W-1:0]   CAP        = CNT_W'(MAX_LINES);

  logic [OFF_W-1:0]      srcOff, dstOff;
  logic [PITCH_W-1:0]    srcPitchR, dstPitchR;
  logic [LB_W-1:0]       lineBytesR;
  logic [CNT_W-1:0]      linesLeft;
  logic [PAGE_SHIFT-1:0] tailBytes;
  logic [LINES_W-1:0]    chunk;

  logic [OFF_W-1:0] srcStart, dstStart;
  logic [OFF_W-1:0] srcStep, dstStep;

  // start offsets: base + row*pitch + column*pixel size
  assign srcStart = srcBase + OFF_W'(srcY) * OFF_W'(srcPitch)
                            + OFF_W'(srcX) * OFF_W'(bytesPerPx);
  assign dstStart = dstBase + OFF_W'(dstY) * OFF_W'(dstPitch)
                            + OFF_W'(dstX) * OFF_W'(bytesPerPx);

  assign chunk   = (linesLeft > CAP) ? LINES_W'(MAX_LINES) : LINES_W'(linesLeft);
  assign srcStep = OFF_W'(srcPitchR) * OFF_W'(chunk);
  assign dstStep = OFF_W'(dstPitchR) * OFF_W'(chunk);

  assign haveLines = (linesLeft != '0);
  assign haveRem   = (tailBytes != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcOff     <= '0;
      dstOff     <= '0;
      srcPitchR  <= '0;
      dstPitchR  <= '0;
      lineBytesR <= '0;
      linesLeft  <= '0;
      tailBytes  <= '0;
    end else if (ctl.load) begin
      if (jobFlat) begin
        srcOff     <= srcBase;
        dstOff     <= dstBase;
        srcPitchR  <= PAGE_PITCH;
        dstPitchR  <= PAGE_PITCH;
        lineBytesR <= PAGE_LB;
        linesLeft  <= CNT_W'(flatLen >> PAGE_SHIFT);
        tailBytes  <= flatLen[PAGE_SHIFT-1:0];
      end else begin
        srcOff     <= srcStart;
        dstOff     <= dstStart;
        srcPitchR  <= srcPitch;
        dstPitchR  <= dstPitch;
        lineBytesR <= LB_W'(widthPx) * LB_W'(bytesPerPx);
        linesLeft  <= CNT_W'(lineCount);
        tailBytes  <= '0;
      end
    end else if (ctl.advance) begin
      srcOff    <= srcOff + srcStep;
      dstOff    <= dstOff + dstStep;
      linesLeft <= linesLeft - CNT_W'(chunk);
    end else if (ctl.loadRem) begin
      srcPitchR  <= PITCH_W'(tailBytes);
      dstPitchR  <= PITCH_W'(tailBytes);
      lineBytesR <= LB_W'(tailBytes);
      linesLeft  <= CNT_W'(1);
      tailBytes  <= '0;
    end
  end

  // marker items carry all-zero fields
  always_comb begin
    if (ctl.kind == KIND_COPY) begin
      outSrcOff    = srcOff;
      outDstOff    = dstOff;
      outSrcPitch  = srcPitchR;
      outDstPitch  = dstPitchR;
      outLineBytes = lineBytesR;
      outLines     = chunk;
    end else begin
      outSrcOff    = '0;
      outDstOff    = '0;
      outSrcPitch  = '0;
      outDstPitch  = '0;
      outLineBytes = '0;
      outLines     = '0;
    end
  end

endmodule

// File: rtl/strided_copy_chunker.sv
module strided_copy_chunker
  import scc_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int PITCH_W    = 16,
  parameter int DIM_W      = 16,
  parameter int BPP_W      = 3,
  parameter int LEN_W      = 32,
  parameter int MAX_LINES  = 2047,
  parameter int PAGE_SHIFT = 12,
  localparam int LB_W      = DIM_W + BPP_W,
  localparam int LINES_W   = $clog2(MAX_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               jobValid,
  output logic               jobReady,
  input  logic               jobFlat,
  input  logic [OFF_W-1:0]   srcBase,
  input  logic [OFF_W-1:0]   dstBase,
  input  logic [PITCH_W-1:0] srcPitch,
  input  logic [PITCH_W-1:0] dstPitch,
  input  logic [DIM_W-1:0]   srcX,
  input  logic [DIM_W-1:0]   srcY,
  input  logic [DIM_W-1:0]   dstX,
  input  logic [DIM_W-1:0]   dstY,
  input  logic [DIM_W-1:0]   widthPx,
  input  logic [BPP_W-1:0]   bytesPerPx,
  input  logic [DIM_W-1:0]   lineCount,
  input  logic [LEN_W-1:0]   flatLen,
  output logic               cmdValid,
  input  logic               cmdReady,
  output logic [1:0]         cmdKind,
  output logic [OFF_W-1:0]   cmdSrcOff,
  output logic [OFF_W-1:0]   cmdDstOff,
  output logic [PITCH_W-1:0] cmdSrcPitch,
  output logic [PITCH_W-1:0] cmdDstPitch,
  output logic [LB_W-1:0]    cmdLineBytes,
  output logic [LINES_W-1:0] cmdLines,
  output logic               done
);

  dp_ctrl_t ctl;
  logic     haveLines, haveRem;

  scc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .jobValid (jobValid),
    .cmdReady (cmdReady),
    .haveLines(haveLines),
    .haveRem  (haveRem),
    .jobReady (jobReady),
    .cmdValid (cmdValid),
    .done     (done),
    .ctl      (ctl)
  );

  scc_datapath #(
    .OFF_W     (OFF_W),
    .PITCH_W   (PITCH_W),
    .DIM_W     (DIM_W),
    .BPP_W     (BPP_W),
    .LEN_W     (LEN_W),
    .MAX_LINES (MAX_LINES),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .jobFlat     (jobFlat),
    .srcBase     (srcBase),
    .dstBase     (dstBase),
    .srcPitch    (srcPitch),
    .dstPitch    (dstPitch),
    .srcX        (srcX),
    .srcY        (srcY),
    .dstX        (dstX),
    .dstY        (dstY),
    .widthPx     (widthPx),
    .bytesPerPx  (bytesPerPx),
    .lineCount   (lineCount),
    .flatLen     (flatLen),
    .haveLines   (haveLines),
    .haveRem     (haveRem),
    .outSrcOff   (cmdSrcOff),
    .outDstOff   (cmdDstOff),
    .outSrcPitch (cmdSrcPitch),
    .outDstPitch (cmdDstPitch),
    .outLineBytes(cmdLineBytes),
    .outLines    (cmdLines)
  );

  assign cmdKind = ctl.kind;

endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int OFF_W     = 32,
  parameter int PITCH_W   = 16,
  parameter int LB_W      = 19,
  parameter int LINES_W   = 11,
  parameter int MAX_LINES = 2047
) (
  input logic               clk,
  input logic               rst_n,
  input logic               jobReady,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [1:0]         cmdKind,
  input logic [OFF_W-1:0]   cmdSrcOff,
  input logic [OFF_W-1:0]   cmdDstOff,
  input logic [PITCH_W-1:0] cmdSrcPitch,
  input logic [PITCH_W-1:0] cmdDstPitch,
  input logic [LB_W-1:0]    cmdLineBytes,
  input logic [LINES_W-1:0] cmdLines,
  input logic               done
);

  p_lines_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdKind == 2'd0) |-> (cmdLines != '0 && cmdLines <= LINES_W'(MAX_LINES)));

  p_nop_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdReady && cmdKind == 2'd0) |=> (cmdValid && cmdKind == 2'd1));

  p_flush_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdReady && cmdKind == 2'd1) |=> (cmdValid && cmdKind == 2'd2));

  p_marker_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdKind != 2'd0) |-> (cmdSrcOff == '0 && cmdDstOff == '0 &&
      cmdSrcPitch == '0 && cmdDstPitch == '0 && cmdLineBytes == '0 && cmdLines == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdKind) && $stable(cmdSrcOff) &&
      $stable(cmdDstOff) && $stable(cmdSrcPitch) && $stable(cmdDstPitch) &&
      $stable(cmdLineBytes) && $stable(cmdLines)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    jobReady |-> !cmdValid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind strided_copy_chunker scc_checker #(
  .OFF_W    (OFF_W),
  .PITCH_W  (PITCH_W),
  .LB_W     (LB_W),
  .LINES_W  (LINES_W),
  .MAX_LINES(MAX_LINES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .jobReady    (jobReady),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .cmdKind     (cmdKind),
  .cmdSrcOff   (cmdSrcOff),
  .cmdDstOff   (cmdDstOff),
  .cmdSrcPitch (cmdSrcPitch),
  .cmdDstPitch (cmdDstPitch),
  .cmdLineBytes(cmdLineBytes),
  .cmdLines    (cmdLines),
  .done        (done)
);

// File: tb/tb_strided_copy_chunker.sv
`timescale 1ns/1ps
module tb_strided_copy_chunker;

  localparam int CAPL = 2047;
  localparam int PAGE = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jobValid = 1'b0;
  logic        jobReady;
  logic        jobFlat = 1'b0;
  logic [31:0] srcBase = '0, dstBase = '0;
  logic [15:0] srcPitch = '0, dstPitch = '0;
  logic [15:0] srcX = '0, srcY = '0, dstX = '0, dstY = '0;
  logic [15:0] widthPx = '0, lineCount = '0;
  logic [2:0]  bytesPerPx = '0;
  logic [31:0] flatLen = '0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [1:0]  cmdKind;
  logic [31:0] cmdSrcOff, cmdDstOff;
  logic [15:0] cmdSrcPitch, cmdDstPitch;
  logic [18:0] cmdLineBytes;
  logic [10:0] cmdLines;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  strided_copy_chunker dut (
    .clk(clk), .rst_n(rst_n), .jobValid(jobValid), .jobReady(jobReady),
    .jobFlat(jobFlat), .srcBase(srcBase), .dstBase(dstBase),
    .srcPitch(srcPitch), .dstPitch(dstPitch), .srcX(srcX), .srcY(srcY),
    .dstX(dstX), .dstY(dstY), .widthPx(widthPx), .bytesPerPx(bytesPerPx),
    .lineCount(lineCount), .flatLen(flatLen), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdKind(cmdKind), .cmdSrcOff(cmdSrcOff),
    .cmdDstOff(cmdDstOff), .cmdSrcPitch(cmdSrcPitch), .cmdDstPitch(cmdDstPitch),
    .cmdLineBytes(cmdLineBytes), .cmdLines(cmdLines), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmpFields(input int kind, input longint so, input longint dOff,
                           input longint sp, input longint dp, input longint lb,
                           input longint ln, input string req);
    chk(cmdValid == 1'b1, req, "cmdValid", cmdValid, 1);
    chk(cmdKind == kind, (kind == 0) ? req : "R5", "kind", cmdKind, kind);
    chk(cmdSrcOff == so, req, "srcOff", cmdSrcOff, so);
    chk(cmdDstOff == dOff, req, "dstOff", cmdDstOff, dOff);
    chk(cmdSrcPitch == sp, req, "srcPitch", cmdSrcPitch, sp);
    chk(cmdDstPitch == dp, req, "dstPitch", cmdDstPitch, dp);
    chk(cmdLineBytes == lb, req, "lineBytes", cmdLineBytes, lb);
    chk(cmdLines == ln, (kind == 0) ? "R2" : "R5", "lines", cmdLines, ln);
  endtask

  // waits for an item on a falling edge, optionally stalls, then accepts it
  task automatic takeCmd(input int kind, input longint so, input longint dOff,
                         input longint sp, input longint dp, input longint lb,
                         input longint ln, input string req, input int stall);
    int waitN = 0;
    while (!cmdValid && waitN < 50) begin
      @(negedge clk);
      waitN++;
    end
    for (int i = 0; i < stall; i++) begin
      cmpFields(kind, so, dOff, sp, dp, lb, ln, "R9");
      @(negedge clk);
    end
    cmpFields(kind, so, dOff, sp, dp, lb, ln, req);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic takeTriple(input longint so, input longint dOff, input longint sp,
                            input longint dp, input longint lb, input longint ln,
                            input string req, input int stall);
    takeCmd(0, so, dOff, sp, dp, lb, ln, req, stall);
    takeCmd(1, 0, 0, 0, 0, 0, 0, "R5", 0);
    takeCmd(2, 0, 0, 0, 0, 0, 0, "R5", 0);
  endtask

  // expected chunk sequence rebuilt from R2/R3
  task automatic takeRun(input longint so, input longint dOff, input longint sp,
                         input longint dp, input longint lb, input longint total,
                         input string req);
    longint left = total;
    longint s = so;
    longint d = dOff;
    while (left > 0) begin
      longint n = (left > CAPL) ? CAPL : left;
      takeTriple(s & 32'hFFFF_FFFF, d & 32'hFFFF_FFFF, sp, dp, lb, n, req, 0);
      s += sp * n;
      d += dp * n;
      left -= n;
    end
  endtask

  task automatic expectDone(input string req);
    chk(done == 1'b1, req, "done high", done, 1);
    chk(jobReady == 1'b1, "R10", "jobReady after job", jobReady, 1);
    chk(cmdValid == 1'b0, "R10", "no item after job", cmdValid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
  endtask

  task automatic submit(input bit flat);
    jobFlat  = flat;
    jobValid = 1'b1;
    @(negedge clk);
    jobValid = 1'b0;
  endtask

  task automatic setStrided(input int sb, input int db, input int sp, input int dp,
                            input int sx, input int sy, input int dx, input int dy,
                            input int w, input int bpp, input int lines);
    srcBase = sb; dstBase = db; srcPitch = sp; dstPitch = dp;
    srcX = sx; srcY = sy; dstX = dx; dstY = dy;
    widthPx = w; bytesPerPx = bpp; lineCount = lines;
  endtask

  task automatic testReset();
    chk(jobReady == 1'b1, "R10", "reset jobReady", jobReady, 1);
    chk(cmdValid == 1'b0, "R10", "reset cmdValid", cmdValid, 0);
    chk(done == 1'b0, "R10", "reset done", done, 0);
  endtask

  // R1 R4 R9: small rectangle, first item timing, stalled handshake
  task automatic testSimple();
    longint so, dOff;
    setStrided(32'h1000, 32'h8000, 256, 512, 3, 5, 7, 2, 10, 4, 6);
    so   = 32'h1000 + 5 * 256 + 3 * 4;
    dOff = 32'h8000 + 2 * 512 + 7 * 4;
    submit(1'b0);
    chk(cmdValid == 1'b0, "R1", "valid during setup", cmdValid, 0);
    chk(jobReady == 1'b0, "R10", "busy after accept", jobReady, 0);
    @(negedge clk);
    chk(cmdValid == 1'b1, "R1", "first item due", cmdValid, 1);
    takeTriple(so, dOff, 256, 512, 10 * 4, 6, "R1", 3);
    expectDone("R10");
  endtask

  // R2 R3: tall job split over several commands, byte-sized pixels
  task automatic testTall();
    longint so, dOff;
    setStrided(32'h0000_0100, 32'h0200_0000, 64, 96, 1, 0, 0, 9, 33, 1, 5000);
    so   = 32'h100 + 1;
    dOff = 32'h0200_0000 + 9 * 96;
    submit(1'b0);
    takeRun(so, dOff, 64, 96, 33, 5000, "R3");
    expectDone("R2");
  endtask

  // R4: three-byte pixels and exactly one full chunk
  task automatic testExactCap();
    setStrided(0, 32'h40, 128, 128, 0, 0, 2, 1, 20, 3, CAPL);
    submit(1'b0);
    takeRun(0, 32'h40 + 128 + 6, 128, 128, 60, CAPL, "R4");
    expectDone("R2");
  endtask

  // R6 R7: pages followed by a short tail
  task automatic testFlatTail();
    srcBase = 32'h0010_0000; dstBase = 32'h0030_0000;
    flatLen = 3 * PAGE + 100;
    submit(1'b1);
    takeRun(32'h0010_0000, 32'h0030_0000, PAGE, PAGE, PAGE, 3, "R6");
    takeTriple(32'h0010_0000 + 3 * PAGE, 32'h0030_0000 + 3 * PAGE,
               100, 100, 100, 1, "R7", 0);
    expectDone("R7");
  endtask

  // R6: more pages than one command holds, no tail
  task automatic testFlatBig();
    srcBase = 32'h0; dstBase = 32'h1000_0000;
    flatLen = 2050 * PAGE;
    submit(1'b1);
    takeRun(0, 32'h1000_0000, PAGE, PAGE, PAGE, 2050, "R6");
    expectDone("R6");
  endtask

  // R7: tail only, under one page
  task automatic testFlatTiny();
    srcBase = 32'h0000_0500; dstBase = 32'h0000_0900;
    flatLen = 50;
    submit(1'b1);
    takeTriple(32'h500, 32'h900, 50, 50, 50, 1, "R7", 2);
    expectDone("R7");
  endtask

  // R8: empty jobs in both modes
  task automatic testEmpty(input bit flat);
    if (flat) flatLen = 0;
    else setStrided(32'h100, 32'h200, 16, 16, 0, 0, 0, 0, 4, 4, 0);
    submit(flat);
    chk(done == 1'b0, "R8", "done not yet", done, 0);
    chk(cmdValid == 1'b0, "R8", "no item in setup", cmdValid, 0);
    @(negedge clk);
    expectDone("R8");
    chk(cmdValid == 1'b0, "R8", "still no item", cmdValid, 0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSimple();
    testTall();
    testExactCap();
    testFlatTail();
    testFlatBig();
    testFlatTiny();
    testEmpty(1'b0);
    testEmpty(1'b1);
    finishRun();
  end

endmodule